// File: doc/BRIEF.md
# 8x8 Integer Cosine Transform Pipeline

This block computes the forward two-dimensional 8x8 integer cosine transform of a stream of signed image samples. It uses a fixed integer basis whose odd rows are built from the weights 10, 9, 6 and 2, and whose even rows 2 and 6 are built from 3 and 1. Every constant product is formed from shifts and additions, so the datapath has no general multiplier. Samples enter one per clock. An 8-point one-dimensional unit transforms each row. A ping-pong transpose store then hands the row results, column by column, to a second copy of the same unit. Coefficients leave one per clock at full precision with no rounding.

A block is 64 samples in raster order, row by row. It is marked by a start flag on its first sample and must be presented on 64 consecutive valid cycles. The next block may follow in the very next cycle or after any gap. Inside each one-dimensional unit the constant-multiply network is shared between coefficient pairs. That network advances only on an internally generated enable at half the sample rate, producing one even and one odd coefficient per enable.

Top module: `ict2d_core`

## Requirements
- R1: Each output value equals F[i][j] = sum over r,c of C[i][r]·x[r][c]·C[j][c], exactly, with C given by these rows. Row 0 is all ones. Row 1 is [10 9 6 2 -2 -6 -9 -10]. Row 2 is [3 1 -1 -3 -3 -1 1 3]. Row 3 is [9 -2 -10 -6 6 10 2 -9]. Row 4 is [1 -1 -1 1 1 -1 -1 1]. Row 5 is [6 -10 2 9 -9 -2 10 -6]. Row 6 is [1 -3 3 -1 -1 3 -3 1]. Row 7 is [2 -6 9 -10 10 -9 6 -2].
- R2: Input sample number n of a block (0..63) is x[n/8][n%8]. Output number n of a block is F[n%8][n/8], so the vertical frequency index runs fastest.
- R3: The first output of a block appears exactly 85 cycles after its first input sample. `out_sop` is high on that output and on no other output.
- R4: When blocks arrive back to back, their outputs are also back to back, with `out_valid` staying high across the boundary.
- R5: Whatever the gap between input blocks, the 64 outputs of every block occupy 64 consecutive cycles.
- R6: A valid sample that arrives while no block is open has no effect on the outputs, and neither does a start flag with `in_valid` low. A block is opened only by `in_valid` and `in_sop` high together.
- R7: While `rst_n` is low at a clock edge, the block is cleared. Afterwards `out_valid` and `out_sop` stay low until a new block has passed through, and a partially received block is discarded.
- R8: Inputs at the extremes (+255 and -256 in any pattern) produce exact results with no overflow in the 21-bit output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample on `in_data` is present |
| in_sop | input | 1 | First sample of a 64-sample block |
| in_data | input | IN_W (9) | Signed input sample |
| out_valid | output | 1 | Coefficient on `out_data` is present |
| out_sop | output | 1 | First coefficient of a block |
| out_data | output | IN_W+12 (21) | Signed transform coefficient |

## Verification
The hardest condition to reach is the moment when one bank of the transpose store is being read column by column while the other bank is being written row by row. At that moment the row unit's serialiser is rolling straight into its next row with no idle cycle. This only happens when several blocks are driven with zero gap. The stimulus therefore sends runs of back-to-back random blocks, interleaved with blocks separated by random gaps. Directed blocks cover impulses at known positions (which pin down the output ordering) and all-extreme patterns (which exercise the widest sums). Stray valid samples, a start flag with valid low, and a reset in the middle of a block cover the paths that must leave the outputs idle.

// File: rtl/ict_pkg.sv
// Shared constants for the 8x8 integer cosine transform pipeline.
// Assumes a fixed 8-point transform; all latencies below are derived from it.
package ict_pkg;
    localparam int PTS        = 8;               // points per 1-D transform
    localparam int BLK        = PTS * PTS;       // samples per 2-D block
    localparam int GROWTH     = 6;               // bits gained per 1-D pass (27*2 < 64)
    localparam int UNIT_LAT   = PTS - 1 + 3;     // first input to first output of a 1-D unit
    localparam int XPOSE_LAT  = 2;               // last write to first read data
    localparam int LAT        = UNIT_LAT + (BLK - 1) + XPOSE_LAT + UNIT_LAT;
endpackage

// File: rtl/ict_1d_unit.sv
// 8-point one-dimensional forward integer cosine transform, serial in and out.
// Collects 8 samples; on the flagged last one, registers the butterfly sums and
// differences. A half-rate enable then drives one shared shift-add network that
// yields an even/odd coefficient pair every second cycle. The pairs are
// serialised in order 0..7, starting 3 cycles after the last input.
// Assumes the 8 samples of a vector arrive on consecutive valid cycles.
module ict_1d_unit #(
    parameter int  IN_W  = 9,
    localparam int OUT_W = IN_W + ict_pkg::GROWTH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic                    smp_last,
    input  logic signed [IN_W-1:0]  smp_data,
    output logic                    coef_valid,
    output logic signed [OUT_W-1:0] coef_data
);
    import ict_pkg::*;

    localparam int BW   = IN_W + 1;
    localparam int HALF = PTS / 2;

    logic signed [IN_W-1:0]  hist   [0:PTS-2];
    logic signed [IN_W-1:0]  vec    [0:PTS-1];
    logic signed [BW-1:0]    sum_w  [0:HALF-1];
    logic signed [BW-1:0]    dif_w  [0:HALF-1];
    logic signed [BW-1:0]    sum_r  [0:HALF-1];
    logic signed [BW-1:0]    dif_r  [0:HALF-1];
    logic                    run;
    logic [2:0]              seq;
    logic                    half_en;
    logic [1:0]              pair_idx;
    logic signed [OUT_W-1:0] e_a, e_b, e_p, e_q;
    logic signed [OUT_W-1:0] d0, d1, d2, d3;
    logic signed [OUT_W-1:0] w10, w9, w6, w2;
    logic signed [OUT_W-1:0] even_w, odd_w;
    logic signed [OUT_W-1:0] even_r, odd_r;
    logic                    run_d;
    logic                    odd_sel_d;

    // Sample history: shift each accepted sample into the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PTS - 1; i++) hist[i] <= '0;
        end else if (smp_valid) begin
            hist[0] <= smp_data;
            for (int i = 1; i < PTS - 1; i++) hist[i] <= hist[i-1];
        end
    end

    // Assemble the full vector in index order; the newest sample is element 7.
    for (genvar j = 0; j < PTS; j++) begin : g_vec
        if (j == PTS - 1) begin : g_new
            assign vec[j] = smp_data;
        end else begin : g_old
            assign vec[j] = hist[PTS-2-j];
        end
    end

    // Symmetric butterflies: sums feed the even rows, differences the odd rows.
    for (genvar i = 0; i < HALF; i++) begin : g_bfly
        assign sum_w[i] = BW'(vec[i]) + BW'(vec[PTS-1-i]);
        assign dif_w[i] = BW'(vec[i]) - BW'(vec[PTS-1-i]);
    end

    // Butterfly register: loaded once per vector on the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HALF; i++) begin
                sum_r[i] <= '0;
                dif_r[i] <= '0;
            end
        end else if (smp_valid && smp_last) begin
            for (int i = 0; i < HALF; i++) begin
                sum_r[i] <= sum_w[i];
                dif_r[i] <= dif_w[i];
            end
        end
    end

    // Output sequencer: counts the 8 output slots of the current vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            seq <= '0;
        end else if (smp_valid && smp_last) begin
            run <= 1'b1;
            seq <= '0;
        end else if (run) begin
            seq <= seq + 3'd1;
            if (seq == 3'd7) run <= 1'b0;
        end
    end

    // Half-rate enable derived from the slot counter.
    assign half_en  = run && !seq[0];
    assign pair_idx = seq[2:1];

    // Even-row operands: outer and inner sums and differences.
    assign e_a = OUT_W'(sum_r[0]) + OUT_W'(sum_r[3]);
    assign e_b = OUT_W'(sum_r[1]) + OUT_W'(sum_r[2]);
    assign e_p = OUT_W'(sum_r[0]) - OUT_W'(sum_r[3]);
    assign e_q = OUT_W'(sum_r[1]) - OUT_W'(sum_r[2]);

    // Even coefficient of the current pair (rows 0, 2, 4, 6).
    always_comb begin
        unique case (pair_idx)
            2'd0:    even_w = e_a + e_b;
            2'd1:    even_w = (e_p <<< 1) + e_p + e_q;
            2'd2:    even_w = e_a - e_b;
            default: even_w = e_p - ((e_q <<< 1) + e_q);
        endcase
    end

    assign d0 = OUT_W'(dif_r[0]);
    assign d1 = OUT_W'(dif_r[1]);
    assign d2 = OUT_W'(dif_r[2]);
    assign d3 = OUT_W'(dif_r[3]);

    // Odd-row operand routing: each odd row is a signed permutation of d0..d3
    // against the fixed weights 10, 9, 6, 2.
    always_comb begin
        unique case (pair_idx)
            2'd0:    begin w10 = d0;  w9 = d1; w6 = d2;  w2 = d3;  end
            2'd1:    begin w10 = -d2; w9 = d0; w6 = -d3; w2 = -d1; end
            2'd2:    begin w10 = -d1; w9 = d3; w6 = d0;  w2 = d2;  end
            default: begin w10 = -d3; w9 = d2; w6 = -d1; w2 = d0;  end
        endcase
    end

    // Shared shift-add network for the odd coefficient.
    assign odd_w = (w10 <<< 3) + (w10 <<< 1)
                 + (w9  <<< 3) + w9
                 + (w6  <<< 2) + (w6  <<< 1)
                 + (w2  <<< 1);

    // Pair register: updated only on the half-rate enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            even_r <= '0;
            odd_r  <= '0;
        end else if (half_en) begin
            even_r <= even_w;
            odd_r  <= odd_w;
        end
    end

    // Slot tracking one cycle behind the sequencer, aligned to the pair register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_d     <= 1'b0;
            odd_sel_d <= 1'b0;
        end else begin
            run_d     <= run;
            odd_sel_d <= seq[0];
        end
    end

    // Serialiser: even member first, odd member second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef_valid <= 1'b0;
            coef_data  <= '0;
        end else begin
            coef_valid <= run_d;
            if (run_d) coef_data <= odd_sel_d ? odd_r : even_r;
        end
    end
endmodule

// File: rtl/ict_transpose_pp.sv
// Ping-pong transpose store between the row and column passes.
// Writes arrive row-major (row index slow, coefficient index fast) into one
// bank. When a bank fills, reading starts at once, column-major, from that
// bank while the other bank takes the next block. Read data is registered.
// Assumes each block's 64 writes arrive on consecutive cycles.
module ict_transpose_pp #(
    parameter int W = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic signed [W-1:0] wr_data,
    output logic                rd_valid,
    output logic                rd_last,
    output logic signed [W-1:0] rd_data
);
    import ict_pkg::*;

    localparam int AW    = $clog2(BLK);
    localparam int HW    = $clog2(PTS);
    localparam int DEPTH = 2 * BLK;

    logic signed [W-1:0] mem [0:DEPTH-1];
    logic [AW-1:0]       wr_cnt;
    logic                wr_bank;
    logic [AW-1:0]       rd_cnt;
    logic                rd_bank;
    logic                rd_run;
    logic                bank_full;
    logic [AW:0]         rd_addr;

    assign bank_full = wr_valid && (wr_cnt == AW'(BLK - 1));

    // Write side: fill the current bank, then flip to the other one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt  <= '0;
            wr_bank <= 1'b0;
        end else if (wr_valid) begin
            wr_cnt <= wr_cnt + 1'b1;
            if (bank_full) wr_bank <= !wr_bank;
        end
    end

    // Storage array: row-major address within the selected bank.
    always_ff @(posedge clk) begin
        if (wr_valid) mem[{wr_bank, wr_cnt}] <= wr_data;
    end

    // Read sequencer: starts on a full bank and walks it for one block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_run  <= 1'b0;
            rd_cnt  <= '0;
            rd_bank <= 1'b0;
        end else if (bank_full) begin
            rd_run  <= 1'b1;
            rd_cnt  <= '0;
            rd_bank <= wr_bank;
        end else if (rd_run) begin
            rd_cnt <= rd_cnt + 1'b1;
            if (rd_cnt == AW'(BLK - 1)) rd_run <= 1'b0;
        end
    end

    // Transposed address: the read count's low bits select the row.
    assign rd_addr = {rd_bank, rd_cnt[HW-1:0], rd_cnt[AW-1:HW]};

    // Registered read port with column-end marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_run;
            rd_last  <= rd_run && (rd_cnt[HW-1:0] == HW'(PTS - 1));
            if (rd_run) rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/ict2d_core.sv
// Top level of the 8x8 forward integer cosine transform.
// Frames input blocks from the start flag, runs a row pass, a ping-pong
// transpose and a column pass, and marks the first output of each block.
// Assumes every block's 64 samples are on consecutive valid cycles.
module ict2d_core #(
    parameter int  IN_W  = 9,
    localparam int OUT_W = IN_W + 2 * ict_pkg::GROWTH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sop,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic                    out_sop,
    output logic signed [OUT_W-1:0] out_data
);
    import ict_pkg::*;

    localparam int MID_W = IN_W + GROWTH;
    localparam int AW    = $clog2(BLK);
    localparam int HW    = $clog2(PTS);

    logic                    blk_open;
    logic [AW-1:0]           in_cnt;
    logic [AW-1:0]           cur_idx;
    logic                    take;
    logic                    row_end;
    logic                    row_valid;
    logic signed [MID_W-1:0] row_data;
    logic                    col_in_valid;
    logic                    col_in_last;
    logic signed [MID_W-1:0] col_in_data;
    logic [AW-1:0]           out_cnt;

    assign cur_idx = in_sop ? '0 : in_cnt;
    assign take    = in_valid && (in_sop || blk_open);
    assign row_end = take && (cur_idx[HW-1:0] == HW'(PTS - 1));

    // Input framing: a start flag opens a block for 64 samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_open <= 1'b0;
            in_cnt   <= '0;
        end else if (take) begin
            in_cnt   <= cur_idx + 1'b1;
            blk_open <= (cur_idx != AW'(BLK - 1));
        end
    end

    ict_1d_unit #(.IN_W(IN_W)) u_row (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (take),
        .smp_last   (row_end),
        .smp_data   (in_data),
        .coef_valid (row_valid),
        .coef_data  (row_data)
    );

    ict_transpose_pp #(.W(MID_W)) u_xpose (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (row_valid),
        .wr_data  (row_data),
        .rd_valid (col_in_valid),
        .rd_last  (col_in_last),
        .rd_data  (col_in_data)
    );

    ict_1d_unit #(.IN_W(MID_W)) u_col (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (col_in_valid),
        .smp_last   (col_in_last),
        .smp_data   (col_in_data),
        .coef_valid (out_valid),
        .coef_data  (out_data)
    );

    // Output position count: marks the first coefficient of each block.
    always_ff @(posedge clk) begin
        if (!rst_n) out_cnt <= '0;
        else if (out_valid) out_cnt <= out_cnt + 1'b1;
    end

    assign out_sop = out_valid && (out_cnt == '0);
endmodule

// File: rtl/ict2d_core_checker.sv
// Timing checker for ict2d_core: tracks accepted input samples independently
// and expects each one to emerge exactly LAT cycles later.
module ict2d_core_checker #(
    parameter int  IN_W  = 9,
    localparam int OUT_W = IN_W + 2 * ict_pkg::GROWTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sop,
    input logic             out_valid,
    input logic             out_sop,
    input logic [OUT_W-1:0] out_data
);
    import ict_pkg::*;

    logic [5:0]     seen;
    logic           open_q;
    logic           acc;
    logic [LAT-1:0] vpipe;
    logic [LAT-1:0] spipe;

    assign acc = in_valid && (in_sop || open_q);

    // Independent block tracker and latency delay lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen   <= '0;
            open_q <= 1'b0;
            vpipe  <= '0;
            spipe  <= '0;
        end else begin
            if (acc) begin
                seen   <= in_sop ? 6'd1 : seen + 6'd1;
                open_q <= in_sop ? 1'b1 : (seen != 6'd63);
            end
            vpipe <= {vpipe[LAT-2:0], acc};
            spipe <= {spipe[LAT-2:0], acc && in_sop};
        end
    end

    assert_sop_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop == spipe[LAT-1]);

    assert_valid_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vpipe[LAT-1]);

    assert_sop_on_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);

    assert_known_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_data));

    assert_idle_after_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !out_valid);
endmodule

bind ict2d_core ict2d_core_checker #(.IN_W(IN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_data  (out_data)
);

// File: tb/ict2d_core_test.sv
module ict2d_core_test;
    localparam int LATENCY = 85;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_sop = 1'b0;
    logic signed [8:0]  in_data = '0;
    logic               out_valid;
    logic               out_sop;
    logic signed [20:0] out_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int stray_seen = 0;
    int mpos = 0;
    int cur_start = 0;
    bit cur_b2b = 0;
    string cur_tag = "R1";

    int    exp_q[$];
    int    start_q[$];
    bit    b2b_q[$];
    string tag_q[$];

    ict2d_core uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int basis(input int i, input int j);
        int row[8];
        case (i)
            0: row = '{1, 1, 1, 1, 1, 1, 1, 1};
            1: row = '{10, 9, 6, 2, -2, -6, -9, -10};
            2: row = '{3, 1, -1, -3, -3, -1, 1, 3};
            3: row = '{9, -2, -10, -6, 6, 10, 2, -9};
            4: row = '{1, -1, -1, 1, 1, -1, -1, 1};
            5: row = '{6, -10, 2, 9, -9, -2, 10, -6};
            6: row = '{1, -3, 3, -1, -1, 3, -3, 1};
            default: row = '{2, -6, 9, -10, 10, -9, 6, -2};
        endcase
        return row[j];
    endfunction

    // Expected outputs in the R2 order: position n holds F[n%8][n/8].
    task automatic push_expect(input int b[64]);
        for (int n = 0; n < 64; n++) begin
            int acc = 0;
            for (int r = 0; r < 8; r++)
                for (int c = 0; c < 8; c++)
                    acc += basis(n % 8, r) * b[r*8 + c] * basis(n / 8, c);
            exp_q.push_back(acc);
        end
    endtask

    task automatic send_block(input int b[64], input string tag, input bit b2b);
        push_expect(b);
        for (int n = 0; n < 64; n++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (n == 0);
            in_data  = 9'(b[n]);
            if (n == 0) begin
                start_q.push_back(cyc + LATENCY);
                tag_q.push_back(tag);
                b2b_q.push_back(b2b);
            end
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sop   = 1'b0;
        end
    endtask

    function automatic void rand_block(output int b[64]);
        for (int n = 0; n < 64; n++) b[n] = int'($urandom_range(0, 511)) - 256;
    endfunction

    // Output monitor, sampled away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                stray_seen++;
            end else begin
                int e;
                if (mpos == 0) begin
                    cur_start = start_q.pop_front();
                    cur_tag   = tag_q.pop_front();
                    cur_b2b   = b2b_q.pop_front();
                    check(out_sop == 1'b1, "R3 out_sop on first", out_sop, 1);
                    check(cyc == cur_start, "R3 latency", cyc, cur_start);
                end else begin
                    check(out_sop == 1'b0, "R3 out_sop only first", out_sop, 0);
                end
                e = exp_q.pop_front();
                check(int'(out_data) == e, cur_tag, int'(out_data), e);
                if (mpos == 63)
                    check(cyc == cur_start + 63, cur_b2b ? "R4 back-to-back stream" : "R5 contiguous stream",
                          cyc, cur_start + 63);
                mpos = (mpos + 1) % 64;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int b[64];
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R7 reset out_valid", out_valid, 0);
        check(out_sop == 1'b0, "R7 reset out_sop", out_sop, 0);

        // R2: single impulses at known positions.
        for (int n = 0; n < 64; n++) b[n] = 0;
        b[0] = 1;
        send_block(b, "R2 impulse 0,0", 0);
        idle(5);
        b[0] = 0; b[2*8 + 5] = 100;
        send_block(b, "R2 impulse 2,5", 0);
        idle(3);

        // R8: extremes.
        for (int n = 0; n < 64; n++) b[n] = 255;
        send_block(b, "R8 all max", 0);
        for (int n = 0; n < 64; n++) b[n] = -256;
        send_block(b, "R8 all min", 1);
        for (int n = 0; n < 64; n++) b[n] = (((n / 8) + (n % 8)) % 2 == 0) ? 255 : -256;
        send_block(b, "R8 checkerboard", 1);
        for (int n = 0; n < 64; n++) b[n] = ((n % 8) < 4) ? 255 : -256;
        send_block(b, "R8 split columns", 1);
        idle(7);

        // R1/R4: a run of back-to-back random blocks.
        for (int k = 0; k < 6; k++) begin
            rand_block(b);
            send_block(b, "R1 random", k != 0);
        end
        // R5: random blocks with random gaps.
        for (int k = 0; k < 6; k++) begin
            idle(int'($urandom_range(1, 40)));
            rand_block(b);
            send_block(b, "R1 random gapped", 0);
        end
        idle(200);
        check(exp_q.size() == 0, "R5 all outputs delivered", exp_q.size(), 0);

        // R6: stray valid samples and a lone start flag must do nothing.
        stray_seen = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = 1'b0; in_data = 9'(k * 7);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = 1'b0; in_data = 9'(k);
        end
        idle(200);
        check(stray_seen == 0, "R6 stray samples ignored", stray_seen, 0);
        rand_block(b);
        send_block(b, "R6 block after strays", 0);
        idle(200);

        // R7: reset in the middle of a block discards it.
        stray_seen = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = (k == 0); in_data = 9'(k * 3);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mpos = 0;
        check(out_valid == 1'b0, "R7 out_valid after mid reset", out_valid, 0);
        idle(150);
        check(stray_seen == 0, "R7 partial block discarded", stray_seen, 0);
        rand_block(b);
        send_block(b, "R7 block after reset", 0);
        idle(200);
        check(exp_q.size() == 0, "R7 block after reset delivered", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule